// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block controls a bank of general-purpose pins (32 by default) through a small word-addressed register bus. Each pin belongs either to the GPIO logic, which drives it from its own output-enable and data bits, or to a peripheral mux that passes through the drive of one of two on-chip peripheral functions. Every per-pin control is held in a flag register that software changes only through paired "set" and "clear" writes. Each write changes only the pins whose bit is 1 in the data word, so no read-modify-write is needed. A third address of each control reads back its current state.

Pad inputs are synchronized, can be passed through a per-pin glitch filter clocked by an internal slow strobe, and are watched for changes in either direction. Changes are latched into a per-pin status register that is cleared when it is read. The bank interrupt line is raised while any latched change falls on an enabled pin. Each pin also has a pull-up control and an open-drain option, in which a driven 1 becomes a released pad.

Top module: `gpio_bank`

## Requirements
- R1: After reset all pins are GPIO-owned, output enables and data are 0, pull-ups are on, and filters, open-drain and interrupt mask are off. `pad_oe` is 0 and `irq` is 0.
- R2: Control k (0 ownership, 1 peripheral-B select, 2 output enable, 3 output data, 4 pull-up, 5 filter, 6 open-drain, 7 interrupt mask) is set at address 3k, cleared at 3k+1 and read at 3k+2. A set or clear write changes only the pins whose data bit is 1.
- R3: A pin whose ownership bit is 0 takes its drive from peripheral B when its select bit is 1, and from peripheral A otherwise. An owned pin takes its drive from its own output-enable and data bits.
- R4: For a GPIO-owned pin, `pad_oe` follows the output-enable bit and `pad_out` follows the data bit.
- R5: `pad_pullup` follows the pull-up bit whatever the pin's owner.
- R6: Address 24 returns the level of every pad input after a two-flop synchronizer, whatever the pin's owner.
- R7: With the filter bit set, a pad level reaches change detection only after it has been seen at two successive strobes (one every `FILT_DIV` cycles). A one-cycle pulse causes no change event.
- R8: With the open-drain bit set, a pin being driven to 1 is released (`pad_oe` 0). A pin being driven to 0 drives low.
- R9: A rising or a falling change of a pin's (filtered) level sets that pin's bit in the status register at address 25, whether or not the pin is enabled. The bit stays set until it is read.
- R10: `irq` is 1 exactly when some status bit is set on a pin whose mask bit is set. The mask reads back at address 23.
- R11: A read of address 25 returns the status and clears it. A change detected in the same cycle as that read is kept and appears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for read-clear of status) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data, one bit per pin |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enable |
| pad_pullup | output | NPINS | Pad pull-up enable |
| pa_out | input | NPINS | Peripheral A output data |
| pa_oe | input | NPINS | Peripheral A output enable |
| pb_out | input | NPINS | Peripheral B output data |
| pb_oe | input | NPINS | Peripheral B output enable |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach is a pin change that is detected in the very cycle the status register is being read, because that event must survive the clear. The bench changes a pad at a falling clock edge and waits for two synchronizer edges. It then issues the status read so that its clearing edge coincides with the change detector's active cycle. It checks that the first read misses the bit and the second read returns it. The glitch filter is checked in a similar way, with a one-cycle pulse that is shorter than a strobe period and a long hold that spans several strobes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum int {
      C_OWN  = 0,
      C_SELB = 1,
      C_OE   = 2,
      C_DAT  = 3,
      C_PU   = 4,
      C_FLT  = 5,
      C_MD   = 6,
      C_IE   = 7
   } ctl_e;

   localparam int NUM_CTL    = 8;
   localparam int ADDR_LEVEL = 3 * NUM_CTL;
   localparam int ADDR_STAT  = ADDR_LEVEL + 1;

   function automatic bit ctl_rst_ones(int idx);
      return (idx == C_OWN) || (idx == C_PU);
   endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int W        = 32,
   parameter bit RST_ONES = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_mask,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] RST_VAL = RST_ONES ? '1 : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= (q & ~clr_mask) | set_mask;
   end
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
   parameter int W           = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pad_in,
   input  logic         tick,
   input  logic [W-1:0] flt_en,
   output logic [W-1:0] level,
   output logic [W-1:0] edg
);
   logic [W-1:0] sync_q [SYNC_STAGES];
   logic [W-1:0] prev_q, held_q, filt, filt_d;
   logic [W-1:0] stable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      end else begin
         sync_q[0] <= pad_in;
         for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      end
   end

   assign level  = sync_q[SYNC_STAGES-1];
   assign stable = ~(level ^ prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         held_q <= '0;
      end else if (tick) begin
         prev_q <= level;
         held_q <= (held_q & ~stable) | (level & stable);
      end
   end

   assign filt = (flt_en & held_q) | (~flt_en & level);

   always_ff @(posedge clk) begin
      if (!rst_n) filt_d <= '0;
      else        filt_d <= filt;
   end

   assign edg = filt ^ filt_d;
endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] edg,
   input  logic         rd_clr,
   input  logic [W-1:0] mask,
   output logic [W-1:0] stat,
   output logic         irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)      stat <= '0;
      else if (rd_clr) stat <= edg;
      else             stat <= stat | edg;
   end

   assign irq = |(stat & mask);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DIV    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_pullup,
   input  logic [NPINS-1:0]  pa_out,
   input  logic [NPINS-1:0]  pa_oe,
   input  logic [NPINS-1:0]  pb_out,
   input  logic [NPINS-1:0]  pb_oe,
   output logic              irq
);
   localparam int DIV_W = (FILT_DIV > 1) ? $clog2(FILT_DIV) : 1;

   if (NPINS > DATA_W) begin : g_err_w
      $error("NPINS must not exceed DATA_W");
   end
   if ((1 << ADDR_W) <= ADDR_STAT) begin : g_err_a
      $error("ADDR_W too small for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_err_s
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_DIV < 2) begin : g_err_d
      $error("FILT_DIV must be at least 2");
   end

   logic [NPINS-1:0] ctl_q [NUM_CTL];
   logic [NPINS-1:0] own_q, selb_q, oe_q, dat_q, pu_q, flt_q, md_q, mask_q;
   logic [NPINS-1:0] level, edg, isr_q;
   logic [NPINS-1:0] drv_oe, drv_dat;
   logic [DIV_W-1:0] div_cnt;
   logic             tick, stat_rd;

   for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
      logic [NPINS-1:0] set_m, clr_m;
      assign set_m = (bus_wr && bus_addr == ADDR_W'(3*g))   ? bus_wdata[NPINS-1:0] : '0;
      assign clr_m = (bus_wr && bus_addr == ADDR_W'(3*g+1)) ? bus_wdata[NPINS-1:0] : '0;
      gpio_setclr_reg #(.W(NPINS), .RST_ONES(ctl_rst_ones(g))) u_reg (
         .clk(clk), .rst_n(rst_n), .set_mask(set_m), .clr_mask(clr_m), .q(ctl_q[g]));
   end

   assign own_q  = ctl_q[C_OWN];
   assign selb_q = ctl_q[C_SELB];
   assign oe_q   = ctl_q[C_OE];
   assign dat_q  = ctl_q[C_DAT];
   assign pu_q   = ctl_q[C_PU];
   assign flt_q  = ctl_q[C_FLT];
   assign md_q   = ctl_q[C_MD];
   assign mask_q = ctl_q[C_IE];

   always_ff @(posedge clk) begin
      if (!rst_n)     div_cnt <= '0;
      else if (tick)  div_cnt <= '0;
      else            div_cnt <= div_cnt + 1'b1;
   end
   assign tick = (div_cnt == DIV_W'(FILT_DIV-1));

   gpio_in_path #(.W(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_in (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .tick(tick),
      .flt_en(flt_q), .level(level), .edg(edg));

   assign stat_rd = bus_rd && (bus_addr == ADDR_W'(ADDR_STAT));

   gpio_irq_stat #(.W(NPINS)) u_stat (
      .clk(clk), .rst_n(rst_n), .edg(edg), .rd_clr(stat_rd),
      .mask(mask_q), .stat(isr_q), .irq(irq));

   assign drv_oe  = (own_q & oe_q)  | (~own_q & ~selb_q & pa_oe)  | (~own_q & selb_q & pb_oe);
   assign drv_dat = (own_q & dat_q) | (~own_q & ~selb_q & pa_out) | (~own_q & selb_q & pb_out);

   assign pad_oe     = drv_oe & ~(md_q & drv_dat);
   assign pad_out    = drv_dat & ~md_q;
   assign pad_pullup = pu_q;

   always_comb begin
      bus_rdata = '0;
      for (int g = 0; g < NUM_CTL; g++) begin
         if (bus_addr == ADDR_W'(3*g+2)) bus_rdata[NPINS-1:0] = ctl_q[g];
      end
      if (bus_addr == ADDR_W'(ADDR_LEVEL)) bus_rdata[NPINS-1:0] = level;
      if (bus_addr == ADDR_W'(ADDR_STAT))  bus_rdata[NPINS-1:0] = isr_q;
   end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  md_q,
   input logic [NPINS-1:0]  mask_q,
   input logic [NPINS-1:0]  own_q,
   input logic [NPINS-1:0]  stat_q,
   input logic [NPINS-1:0]  edg
);
   logic stat_rd;
   assign stat_rd = bus_rd && (bus_addr == ADDR_W'(ADDR_STAT));

   p_own_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(0)) |=>
      ((own_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

   p_open_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_out & md_q) == '0));

   p_edge_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|edg) |=> ((stat_q & $past(edg)) == $past(edg)));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   p_no_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> ((stat_q & ~$past(edg)) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .irq(irq), .pad_oe(pad_oe), .pad_out(pad_out),
   .md_q(md_q), .mask_q(mask_q), .own_q(own_q), .stat_q(isr_q), .edg(edg));

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 32;
   localparam int DIV = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pad_in = '0, pad_out, pad_oe, pad_pullup;
   logic [NP-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
   logic          irq;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank #(.NPINS(NP), .DATA_W(32), .ADDR_W(5), .SYNC_STAGES(2), .FILT_DIV(DIV)) i_gpio_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pullup(pad_pullup), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_out(pb_out), .pb_oe(pb_oe), .irq(irq));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(5'd2, v);  check("R1 own", v, 32'hFFFF_FFFF);
      rd(5'd14, v); check("R1 pullup", v, 32'hFFFF_FFFF);
      rd(5'd8, v);  check("R1 oe", v, 32'h0);
      rd(5'd23, v); check("R1 mask", v, 32'h0);
      check("R1 pad_oe", pad_oe, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'h0);
   endtask

   task automatic t_gpio_drive();
      logic [31:0] v;
      wr(5'd6, 32'h0000_00F0);
      wr(5'd7, 32'h0000_0010);
      rd(5'd8, v); check("R2 masked set/clear", v, 32'h0000_00E0);
      wr(5'd9, 32'h0000_00A0);
      check("R4 pad_oe", pad_oe & 32'hFF, 32'h0000_00E0);
      check("R4 pad_out", pad_out & 32'hFF, 32'h0000_00A0);
   endtask

   task automatic t_periph();
      logic [31:0] v;
      pa_oe = 32'h3; pa_out = 32'h1; pb_oe = 32'h1; pb_out = 32'h2;
      wr(5'd1, 32'h3);
      rd(5'd2, v); check("R3 own readback", v, 32'hFFFF_FFFC);
      check("R3 periph A oe", pad_oe & 32'h3, 32'h3);
      check("R3 periph A out", pad_out & 32'h3, 32'h1);
      wr(5'd3, 32'h2);
      check("R3 periph B oe", pad_oe & 32'h3, 32'h1);
      check("R3 periph B out", pad_out & 32'h3, 32'h3);
      wr(5'd13, 32'h1);
      check("R5 pullup off periph pin", pad_pullup, 32'hFFFF_FFFE);
      pad_in = 32'h0000_5003;
      idle(3);
      rd(5'd24, v); check("R6 level readback", v, 32'h0000_5003);
      pad_in = '0;
      idle(4);
      rd(5'd25, v);
      wr(5'd12, 32'h1);
      wr(5'd4, 32'h2);
      wr(5'd0, 32'h3);
      check("R3 owned pins back to gpio", pad_oe & 32'h3, 32'h0);
   endtask

   task automatic t_open_drain();
      wr(5'd18, 32'h20);
      check("R8 released on 1", pad_oe & 32'h20, 32'h0);
      wr(5'd10, 32'h20);
      check("R8 drive low oe", pad_oe & 32'h20, 32'h20);
      check("R8 drive low out", pad_out & 32'h20, 32'h0);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      rd(5'd25, v);
      wr(5'd21, 32'h100);
      rd(5'd23, v); check("R10 mask readback", v, 32'h100);
      @(negedge clk) pad_in[8] = 1'b1;
      idle(4);
      check("R10 irq on rise", {31'd0, irq}, 32'h1);
      rd(5'd25, v); check("R9 rise latched", v, 32'h100);
      check("R11 irq cleared after read", {31'd0, irq}, 32'h0);
      @(negedge clk) pad_in[8] = 1'b0;
      idle(4);
      rd(5'd25, v); check("R9 fall latched", v, 32'h100);
      @(negedge clk) pad_in[9] = 1'b1;
      idle(4);
      check("R10 unmasked pin no irq", {31'd0, irq}, 32'h0);
      rd(5'd25, v); check("R9 latched without mask", v, 32'h200);
   endtask

   task automatic t_filter();
      logic [31:0] v;
      wr(5'd15, 32'h400);
      idle(4*DIV);
      rd(5'd25, v);
      @(negedge clk) pad_in[10] = 1'b1;
      @(negedge clk) pad_in[10] = 1'b0;
      idle(6*DIV);
      rd(5'd25, v); check("R7 short pulse filtered", v, 32'h0);
      @(negedge clk) pad_in[10] = 1'b1;
      idle(6*DIV);
      rd(5'd25, v); check("R7 long level passes", v, 32'h400);
   endtask

   task automatic t_read_race();
      logic [31:0] v;
      rd(5'd25, v);
      @(negedge clk) pad_in[11] = 1'b1;
      @(negedge clk);
      rd(5'd25, v); check("R11 read in change cycle", v, 32'h0);
      rd(5'd25, v); check("R11 change kept", v, 32'h800);
      rd(5'd25, v); check("R11 cleared", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gpio_drive();
      t_periph();
      t_open_drain();
      t_irq();
      t_filter();
      t_read_race();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule